// File: doc/BRIEF.md
# Input Capture Period Meter

This block measures the time between consecutive edges of an external signal in ticks of a shared free-running counter. The counter is N bits wide and advances once per clock while a tick enable is high. The signal arrives asynchronously. It passes through a synchronizer and an edge detector, and the user picks which edge is active: rising or falling. On each active edge the block takes a snapshot of the counter. It reports that snapshot and the number of ticks since the previous snapshot.

The elapsed value is exact even when the counter wraps between the two edges, once or many times. The block counts wraps between captures and combines that count with the difference of the two snapshots. The synchronizer adds a delay, so a delayed copy of the counter travels next to the synchronized pin. Each snapshot therefore holds the counter value from the cycle when the pin's new level was first sampled.

Two equal snapshots can mean two different things, and the wrap count tells them apart. With no wrap in between, the two edges fell within one tick, and the block flags the result as ambiguous. With one or more wraps, the result is a whole number of laps. Periods too long for the output are reported as the all-ones value.

Top module: `icap_period_meter`

## Requirements
- R1: The tick counter starts at zero after reset. It rises by one on every clock with `tick_en` high, wraps from all-ones to zero, and holds its value while `tick_en` is low.
- R2: When `edge_rise` is 1, only rising edges of `pin_async` are active; when it is 0, only falling edges are. An inactive edge raises no `period_valid` and leaves `cap_value` unchanged.
- R3: On an active edge, `cap_value` takes the counter value of the cycle in which the new pin level was first sampled by a clock edge. It then holds that value until the next active edge.
- R4: `period_valid` is high for exactly one cycle. That cycle follows the third rising clock edge, counted from and including the edge that first samples the new pin level. `cap_value`, `period` and `period_ambig` update on that same edge.
- R5: The first active edge after reset updates `cap_value` only; it raises neither `period_valid` nor `period_ambig`.
- R6: `period` equals the number of enabled ticks between two consecutive active edges. This holds when the later snapshot is numerically smaller than the earlier one (modular difference).
- R7: Periods that span several counter laps are reported exactly. A wrap in the same cycle as a snapshot of all-ones counts toward the following period.
- R8: When the true period exceeds 2^(CNT_W+OVF_W)-1 ticks, `period` is all ones.
- R9: When both snapshots are equal and no wrap occurred, `period_ambig` is raised together with `period_valid` and `period` is 0. When the snapshots are equal after whole laps, `period_ambig` stays low.
- R10: While reset is high and on the cycle after it, `cap_value` and `period` are zero, and `period_valid` and `period_ambig` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances the tick counter this cycle |
| pin_async | input | 1 | Asynchronous signal under measurement |
| edge_rise | input | 1 | 1: rising edges active, 0: falling edges active |
| cap_value | output | CNT_W | Counter snapshot from the last active edge |
| period | output | CNT_W+OVF_W | Ticks between the last two active edges (saturating) |
| period_valid | output | 1 | One-cycle pulse when a new period is reported |
| period_ambig | output | 1 | Equal snapshots with no wrap between them |

## Verification
Three rising clock edges separate a pin change from its result: two synchronizer stages and one output register. The bench drives the pin on a falling clock edge, waits through three rising edges and samples the outputs on the falling edge that follows. It samples once more a cycle later to confirm that the valid pulse has dropped. The expected snapshot and period come from a bench-side count of enabled ticks, taken at the rising edge that first sees the new pin level. Inactive edges are checked on the same three-edge schedule.

// File: rtl/icap_pkg.sv
package icap_pkg;

  // Active edge selection encoding on the edge_rise input.
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;

  // Minimum synchronizer depth supported by the pipeline.
  localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/icap_tick_counter.sv
module icap_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (tick_en) begin
      count <= count + CNT_ONE;
    end
  end

  // The counter rolls to zero at the next edge.
  assign wrap = tick_en && (count == CNT_MAX);

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!rst && tick_en) |=> (count == $past(count) + CNT_ONE)); // R1

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && !tick_en) |=> $stable(count)); // R1

endmodule

// File: rtl/icap_sync_edge.sv
module icap_sync_edge
  import icap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_async,
  input  logic             edge_rise,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             wrap_in,
  output logic             evt,
  output logic [CNT_W-1:0] evt_cnt,
  output logic             evt_wrap
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] lvl_q;
  logic [SYNC_STAGES-1:0] wrap_q;
  logic [CNT_W-1:0]       cnt_q [SYNC_STAGES];
  logic                   prev_lvl;
  logic                   lvl_now;

  generate
    if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
      initial $error("SYNC_STAGES below supported minimum");
    end
  endgenerate

  // Pin level, counter value and wrap flag travel in lockstep, so the
  // snapshot belongs to the cycle that first sampled the new level.
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q    <= '0;
      wrap_q   <= '0;
      prev_lvl <= 1'b0;
      for (int i = 0; i < SYNC_STAGES; i++) begin
        cnt_q[i] <= '0;
      end
    end else begin
      lvl_q    <= {lvl_q[SYNC_STAGES-2:0], pin_async};
      wrap_q   <= {wrap_q[SYNC_STAGES-2:0], wrap_in};
      prev_lvl <= lvl_q[LAST];
      cnt_q[0] <= cnt_in;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        cnt_q[i] <= cnt_q[i-1];
      end
    end
  end

  assign lvl_now  = lvl_q[LAST];
  assign evt      = (edge_rise == EDGE_RISE) ? (lvl_now & ~prev_lvl)
                                             : (~lvl_now & prev_lvl);
  assign evt_cnt  = cnt_q[LAST];
  assign evt_wrap = wrap_q[LAST];

  // Same-direction edges need an opposite edge between them.
  AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt); // R2

endmodule

// File: rtl/icap_period_calc.sv
module icap_period_calc #(
  parameter int CNT_W = 16,
  parameter int OVF_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   evt,
  input  logic [CNT_W-1:0]       evt_cnt,
  input  logic                   evt_wrap,
  output logic [CNT_W-1:0]       cap_value,
  output logic [CNT_W+OVF_W-1:0] period,
  output logic                   period_valid,
  output logic                   period_ambig
);

  localparam int PER_W  = CNT_W + OVF_W;
  localparam int ACC_W  = OVF_W + 1;
  localparam int WIDE_W = ACC_W + CNT_W;
  localparam logic [ACC_W-1:0]  ACC_MAX = '1;
  localparam logic [ACC_W-1:0]  ACC_ONE = ACC_W'(1);
  localparam logic [PER_W-1:0]  PER_MAX = '1;
  localparam logic [WIDE_W-1:0] PER_MAX_WIDE = {1'b0, PER_MAX};

  logic             seeded;
  logic [CNT_W-1:0] last_cap;
  logic [ACC_W-1:0] wraps;
  logic [WIDE_W-1:0] elapsed_wide;
  logic             too_long;
  logic             same_point;

  // Wraps seen since the last snapshot, one extra bit so that the
  // modular difference stays exact up to the saturation point.
  assign elapsed_wide = {wraps, evt_cnt} - {{ACC_W{1'b0}}, last_cap};
  assign too_long     = (wraps == ACC_MAX) || (elapsed_wide > PER_MAX_WIDE);
  assign same_point   = (wraps == '0) && (evt_cnt == last_cap);

  always_ff @(posedge clk) begin
    if (rst) begin
      seeded       <= 1'b0;
      last_cap     <= '0;
      wraps        <= '0;
      cap_value    <= '0;
      period       <= '0;
      period_valid <= 1'b0;
      period_ambig <= 1'b0;
    end else if (evt) begin
      seeded    <= 1'b1;
      last_cap  <= evt_cnt;
      cap_value <= evt_cnt;
      // A wrap alongside this snapshot happens after it: next period.
      wraps     <= evt_wrap ? ACC_ONE : '0;
      if (seeded) begin
        period_valid <= 1'b1;
        period_ambig <= same_point;
        period       <= too_long ? PER_MAX : elapsed_wide[PER_W-1:0];
      end else begin
        period_valid <= 1'b0;
        period_ambig <= 1'b0;
      end
    end else begin
      period_valid <= 1'b0;
      period_ambig <= 1'b0;
      if (evt_wrap && (wraps != ACC_MAX)) begin
        wraps <= wraps + ACC_ONE;
      end
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && !evt) |=> $stable(cap_value)); // R3

  AST_VALID_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!rst && !evt) |=> !period_valid); // R4

  AST_FIRST_EDGE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!rst && evt && !seeded) |=> (!period_valid && !period_ambig)); // R5

  AST_AMBIG_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    period_ambig |-> period_valid); // R9

  AST_AMBIG_ZERO: assert property (@(posedge clk) disable iff (rst)
    period_ambig |-> (period == '0)); // R9

endmodule

// File: rtl/icap_period_meter.sv
module icap_period_meter #(
  parameter int CNT_W       = 16,
  parameter int OVF_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick_en,
  input  logic                   pin_async,
  input  logic                   edge_rise,
  output logic [CNT_W-1:0]       cap_value,
  output logic [CNT_W+OVF_W-1:0] period,
  output logic                   period_valid,
  output logic                   period_ambig
);

  logic [CNT_W-1:0] count;
  logic             wrap;
  logic             evt;
  logic [CNT_W-1:0] evt_cnt;
  logic             evt_wrap;

  icap_tick_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .count   (count),
    .wrap    (wrap)
  );

  icap_sync_edge #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin_async (pin_async),
    .edge_rise (edge_rise),
    .cnt_in    (count),
    .wrap_in   (wrap),
    .evt       (evt),
    .evt_cnt   (evt_cnt),
    .evt_wrap  (evt_wrap)
  );

  icap_period_calc #(
    .CNT_W (CNT_W),
    .OVF_W (OVF_W)
  ) u_calc (
    .clk          (clk),
    .rst          (rst),
    .evt          (evt),
    .evt_cnt      (evt_cnt),
    .evt_wrap     (evt_wrap),
    .cap_value    (cap_value),
    .period       (period),
    .period_valid (period_valid),
    .period_ambig (period_ambig)
  );

endmodule

// File: tb/icap_period_meter_tb.sv
module icap_period_meter_tb;

  localparam int CW   = 4;
  localparam int OW   = 3;
  localparam int PW   = CW + OW;
  localparam longint PMAX = (64'd1 << PW) - 1;
  localparam longint LAP  = 64'd1 << CW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, tick_en, pin, pol;
  logic [CW-1:0] cap_value;
  logic [PW-1:0] period;
  logic          period_valid, period_ambig;

  int checks = 0;
  int fails  = 0;
  int phase  = 0;

  longint abs_t, cur_ev, prev_ev;
  int     nev;
  logic   last_pin;

  icap_period_meter #(
    .CNT_W (CW),
    .OVF_W (OW),
    .SYNC_STAGES (2)
  ) u_dut (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .pin_async    (pin),
    .edge_rise    (pol),
    .cap_value    (cap_value),
    .period       (period),
    .period_valid (period_valid),
    .period_ambig (period_ambig)
  );

  // Bench model of the tick count and of the active edges.
  always @(posedge clk) begin
    if (rst) begin
      abs_t    <= 0;
      cur_ev   <= 0;
      prev_ev  <= 0;
      nev      <= 0;
      last_pin <= 1'b0;
    end else begin
      if (pol ? (pin && !last_pin) : (!pin && last_pin)) begin
        prev_ev <= cur_ev;
        cur_ev  <= abs_t;
        nev     <= nev + 1;
      end
      last_pin <= pin;
      abs_t    <= abs_t + (tick_en ? 1 : 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: set tick enable for the coming rising edge, move to next falling edge.
  task automatic step(input int mode);
    case (mode)
      0: tick_en = 1'b1;
      1: tick_en = (phase % 3 == 0);
      default: tick_en = 1'b0;
    endcase
    phase++;
    @(negedge clk);
  endtask

  task automatic meas(input int gap, input int mode);
    longint d, exp_p;
    string  tag;
    // Inactive edge (or no change) first.
    pin = !pol;
    repeat (3) step(mode);
    chk(period_valid == 1'b0, "R2 inactive edge valid", period_valid, 0);
    chk(cap_value == CW'(cur_ev % LAP), "R2 inactive edge capture", cap_value, cur_ev % LAP);
    // Active edge.
    pin = pol;
    repeat (3) step(mode);
    if (nev == 1) begin
      chk(period_valid == 1'b0, "R5 first edge valid", period_valid, 0);
      chk(period_ambig == 1'b0, "R5 first edge ambig", period_ambig, 0);
      chk(cap_value == CW'(cur_ev % LAP), "R5 first edge capture", cap_value, cur_ev % LAP);
    end else begin
      d     = cur_ev - prev_ev;
      exp_p = (d > PMAX) ? PMAX : d;
      if (d > PMAX) tag = "R8 clamp";
      else if (d >= LAP) tag = "R7 multi-lap";
      else tag = "R6 period";
      chk(period_valid == 1'b1, "R4 valid pulse", period_valid, 1);
      chk(cap_value == CW'(cur_ev % LAP), (mode == 1) ? "R1 gated capture" : "R3 capture",
          cap_value, cur_ev % LAP);
      chk(longint'(period) == exp_p, tag, period, exp_p);
      chk(period_ambig == (d == 0), "R9 ambiguity", period_ambig, (d == 0));
    end
    step(mode);
    chk(period_valid == 1'b0, "R4 pulse width", period_valid, 0);
    for (int g = 0; g < gap; g++) step(mode);
    chk(cap_value == CW'(cur_ev % LAP), "R3 capture hold", cap_value, cur_ev % LAP);
  endtask

  task automatic reset_checks();
    rst = 1'b1;
    pin = 1'b0;
    repeat (3) @(negedge clk);
    chk(cap_value == '0, "R10 reset capture", cap_value, 0);
    chk(period == '0, "R10 reset period", period, 0);
    chk(period_valid == 1'b0 && period_ambig == 1'b0, "R10 reset flags",
        {period_valid, period_ambig}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(period_valid == 1'b0 && cap_value == '0, "R10 after reset", cap_value, 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick_en = 1'b0; pin = 1'b0; pol = 1'b1;
    @(negedge clk);
    reset_checks();

    meas(0, 0);                              // seed (R5)
    for (int g = 0; g <= 130; g++) meas(g, 0);   // R6 R7 R8, exact laps at gap 10
    for (int g = 0; g <= 420; g += 11) meas(g, 1); // R1 gated ticks, long periods
    meas(3, 2); meas(0, 2);                  // R9 sub-tick ambiguity
    meas(10, 0);

    // Switch to falling edges while the pin is quiet.
    repeat (4) step(0);
    pol = 1'b0;
    repeat (4) step(0);
    for (int g = 0; g <= 40; g += 5) meas(g, 0);
    for (int g = 0; g <= 60; g += 13) meas(g, 1);
    meas(2, 2);

    // Second reset: first edge must seed again.
    pin = 1'b0;
    repeat (4) step(0);
    pol = 1'b1;
    reset_checks();
    meas(5, 0);
    meas(7, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule